// File: doc/BRIEF.md
# Steppable User Clock Controller

This block decides, on every cycle of a free-running reference clock, whether the user clock domain gets an edge. It does not make a clock itself. It drives a clock-enable, `clk_en`, that downstream clock gating qualifies on the reference clock. A host issues one-cycle commands to pick the behaviour:

- **Stopped.** No edges are issued.
- **Free-run.** An edge is issued every cycle.
- **Countdown.** A programmed number of edges is issued, then the clock stops.
- **FIFO-step.** Each FIFO write issues a programmed burst of edges. The burst length stays in force for later writes until the host changes it.

Each processing element (PE) drives an active-low halt line. When a PE's line is enabled and a falling edge appears on it, the running clock stops after a fixed drain of three gated edges. The end of a countdown or burst produces a one-cycle `step_done` pulse that feeds an interrupt source. A `busy` output lets the host start a sequence and poll for its end, or simply return and wait for the interrupt.

The controller is one state machine with five states:

- `ST_STOPPED`: no edges.
- `ST_FREERUN`: an edge every cycle.
- `ST_COUNTDOWN`: edges while a remaining count runs down.
- `ST_ARMED`: FIFO-step mode, waiting for a write.
- `ST_DRAIN`: three closing edges after a halt.

The transitions are as follows:

- `OP_STOP` moves any state to `ST_STOPPED`.
- `OP_RUN` moves any state to `ST_FREERUN`.
- `OP_STEP` with a nonzero argument moves any state to `ST_COUNTDOWN`.
- `OP_FIFO` with a nonzero argument moves `ST_STOPPED` or `ST_ARMED` to `ST_ARMED`. With a zero argument it moves `ST_ARMED` to `ST_STOPPED`.
- A FIFO write moves `ST_ARMED` to `ST_COUNTDOWN`.
- When the count is exhausted, `ST_COUNTDOWN` moves to `ST_ARMED` if FIFO-step mode is on, and to `ST_STOPPED` otherwise.
- A detected halt moves `ST_FREERUN` or `ST_COUNTDOWN` to `ST_DRAIN`.
- When its third edge has been issued, `ST_DRAIN` moves to `ST_STOPPED`.

A command in the same cycle as a halt detection takes priority over the halt.

Top module: `stepclk_ctrl`

## Requirements
- R1: After reset, `clk_en`, `busy` and `step_done` are all low, and the controller issues no edges until a command arrives.
- R2: `cmd_op` = 1 (run) holds `clk_en` high on every cycle, starting in the cycle after the command. `cmd_op` = 0 (stop) drops `clk_en` in the cycle after the command.
- R3: `cmd_op` = 2 (step) with a nonzero `cmd_arg` of N gives exactly N consecutive cycles with `clk_en` high, starting in the cycle after the command. `clk_en` is then low.
- R4: `cmd_op` = 2 with `cmd_arg` = 0 is ignored: no edge is issued and no `step_done` is raised.
- R5: `step_done` is high for exactly one cycle, the first cycle after the last counted edge of a countdown or burst. A halt, or a stop command, never raises it.
- R6: `cmd_op` = 3 (FIFO configure) with a nonzero `cmd_arg` of M arms FIFO-step mode, with `clk_en` low while armed. From then on, every `fifo_wr` pulse issues exactly M edges, starting in the cycle after the pulse. M persists across writes.
- R7: A `fifo_wr` that arrives while a burst is still running adds M to the remaining count, so the edges of overlapping bursts add up. The remaining count saturates at its maximum.
- R8: `fifo_wr` is ignored when FIFO-step mode is not armed, including after `cmd_op` = 3 with `cmd_arg` = 0.
- R9: A falling edge on `halt_n[i]` while `halt_en[i]` is high and the clock is running passes through two synchronizer flops and an edge detector. The controller then issues exactly three more edges and stops. Counted from the first cycle after the line falls, `clk_en` is high for exactly five cycles.
- R10: A falling edge on a disabled halt line, a rising edge on any halt line, and a falling edge while the clock is stopped all have no effect on `clk_en`.
- R11: `busy` is high exactly in the cycles in which a countdown or burst is issuing edges, and low in free-run, drain, armed and stopped operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 2 | Command: 0 stop, 1 run, 2 step, 3 FIFO configure |
| cmd_arg | input | CNT_W | Step count or FIFO burst length |
| fifo_wr | input | 1 | One-cycle FIFO write pulse |
| halt_n | input | NUM_PE | Per-PE active-low halt lines, asynchronous |
| halt_en | input | NUM_PE | Per-PE halt enables |
| clk_en | output | 1 | User clock enable, qualified on clk_ref |
| busy | output | 1 | A countdown or burst is in progress |
| step_done | output | 1 | One-cycle pulse when a countdown or burst ends |

## Verification
The hardest case to reach from the ports is a FIFO write landing while a burst is still counting down. To produce it, the bench issues a second `fifo_wr` two cycles into a burst, then checks that the total run length equals both bursts together. The halt drain is also hard to reach while a countdown is active, because the halt edge must arrive well before the count runs out. The bench therefore starts a long step sequence, drops an enabled halt line part way through, and confirms that the run is cut to the synchronizer latency plus three edges with no `step_done`. For the case of a halt edge while stopped, the bench restores the line, drops it with the clock stopped, and only then starts free-run, watching that the old edge has no effect.

// File: rtl/stepclk_pkg.sv
package stepclk_pkg;

    typedef enum logic [1:0] {
        OP_STOP = 2'd0,
        OP_RUN  = 2'd1,
        OP_STEP = 2'd2,
        OP_FIFO = 2'd3
    } stepclk_op_e;

    typedef enum logic [2:0] {
        ST_STOPPED   = 3'd0,
        ST_FREERUN   = 3'd1,
        ST_COUNTDOWN = 3'd2,
        ST_ARMED     = 3'd3,
        ST_DRAIN     = 3'd4
    } stepclk_state_e;

    // Gated edges issued after a halt has been detected.
    localparam int unsigned DRAIN_EDGES = 3;

endpackage

// File: rtl/stepclk_halt_detect.sv
module stepclk_halt_detect #(
    parameter int unsigned NUM_PE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PE-1:0] halt_n,
    input  logic [NUM_PE-1:0] halt_en,
    output logic              halt_req
);

    logic [NUM_PE-1:0] fall_seen;

    for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
        logic sync_a;
        logic sync_b;
        logic last_b;

        // Two-flop synchronizer, then a delayed copy for edge detection.
        // All flops reset high, matching an idle line.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_a <= 1'b1;
                sync_b <= 1'b1;
                last_b <= 1'b1;
            end else begin
                sync_a <= halt_n[g];
                sync_b <= sync_a;
                last_b <= sync_b;
            end
        end

        assign fall_seen[g] = last_b & ~sync_b & halt_en[g];
    end

    assign halt_req = |fall_seen;

endmodule

// File: rtl/stepclk_seq.sv
module stepclk_seq
    import stepclk_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [CNT_W-1:0] cmd_arg,
    input  logic             fifo_wr,
    input  logic             halt_req,
    output logic             clk_en,
    output logic             busy,
    output logic             step_done
);

    localparam int unsigned DRAIN_W = $clog2(DRAIN_EDGES + 1);

    stepclk_state_e   state_q,  state_d;
    logic [CNT_W-1:0] remain_q, remain_d;
    logic [CNT_W-1:0] burst_q,  burst_d;
    logic             fmode_q,  fmode_d;
    logic [DRAIN_W-1:0] drain_q, drain_d;
    logic             done_d;

    logic             running;
    logic [CNT_W-1:0] add_cnt;
    logic [CNT_W:0]   sum_ext;
    logic [CNT_W-1:0] sum_sat;
    stepclk_op_e      op;

    assign op      = stepclk_op_e'(cmd_op);
    assign running = (state_q == ST_FREERUN) || (state_q == ST_COUNTDOWN);
    assign add_cnt = (fifo_wr && fmode_q) ? burst_q : '0;
    assign sum_ext = {1'b0, remain_q} + {1'b0, add_cnt} - (CNT_W+1)'(1);
    assign sum_sat = sum_ext[CNT_W] ? {CNT_W{1'b1}} : sum_ext[CNT_W-1:0];

    // Next-state logic.
    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        burst_d  = burst_q;
        fmode_d  = fmode_q;
        drain_d  = drain_q;
        done_d   = 1'b0;
        if (cmd_valid) begin
            unique case (op)
                OP_STOP: begin
                    state_d  = ST_STOPPED;
                    fmode_d  = 1'b0;
                    remain_d = '0;
                end
                OP_RUN: begin
                    state_d  = ST_FREERUN;
                    fmode_d  = 1'b0;
                    remain_d = '0;
                end
                OP_STEP: begin
                    if (cmd_arg != '0) begin
                        state_d  = ST_COUNTDOWN;
                        remain_d = cmd_arg;
                        fmode_d  = 1'b0;
                    end
                end
                OP_FIFO: begin
                    burst_d = cmd_arg;
                    fmode_d = (cmd_arg != '0);
                    if (state_q == ST_STOPPED || state_q == ST_ARMED) begin
                        state_d = (cmd_arg != '0) ? ST_ARMED : ST_STOPPED;
                    end
                end
                default: ;
            endcase
        end else if (halt_req && running) begin
            state_d  = ST_DRAIN;
            drain_d  = DRAIN_W'(DRAIN_EDGES);
            remain_d = '0;
            fmode_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_STOPPED, ST_FREERUN: ;
                ST_ARMED: begin
                    if (fifo_wr) begin
                        state_d  = ST_COUNTDOWN;
                        remain_d = burst_q;
                    end
                end
                ST_COUNTDOWN: begin
                    if (sum_sat == '0) begin
                        state_d  = fmode_q ? ST_ARMED : ST_STOPPED;
                        remain_d = '0;
                        done_d   = 1'b1;
                    end else begin
                        remain_d = sum_sat;
                    end
                end
                ST_DRAIN: begin
                    if (drain_q == DRAIN_W'(1)) begin
                        state_d = ST_STOPPED;
                        drain_d = '0;
                    end else begin
                        drain_d = drain_q - DRAIN_W'(1);
                    end
                end
                default: state_d = ST_STOPPED;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_STOPPED;
            remain_q  <= '0;
            burst_q   <= '0;
            fmode_q   <= 1'b0;
            drain_q   <= '0;
            step_done <= 1'b0;
        end else begin
            state_q   <= state_d;
            remain_q  <= remain_d;
            burst_q   <= burst_d;
            fmode_q   <= fmode_d;
            drain_q   <= drain_d;
            step_done <= done_d;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        clk_en = 1'b0;
        busy   = 1'b0;
        unique case (state_q)
            ST_FREERUN:   clk_en = 1'b1;
            ST_COUNTDOWN: begin clk_en = 1'b1; busy = 1'b1; end
            ST_DRAIN:     clk_en = 1'b1;
            ST_STOPPED, ST_ARMED: ;
            default: ;
        endcase
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNTDOWN) |-> (remain_q != '0)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done); // R5
    AST_DONE_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> ($past(state_q) == ST_COUNTDOWN)); // R5
    AST_ARMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> !clk_en); // R6
    AST_HALT_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && running && !cmd_valid) |=> (clk_en && !busy)); // R9
    AST_DRAIN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) == ST_DRAIN) && (state_q != ST_DRAIN) && !$past(cmd_valid))
            |-> !clk_en); // R9
    AST_BUSY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> clk_en); // R11

endmodule

// File: rtl/stepclk_ctrl.sv
module stepclk_ctrl
    import stepclk_pkg::*;
#(
    parameter int unsigned NUM_PE = 3,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [CNT_W-1:0]  cmd_arg,
    input  logic              fifo_wr,
    input  logic [NUM_PE-1:0] halt_n,
    input  logic [NUM_PE-1:0] halt_en,
    output logic              clk_en,
    output logic              busy,
    output logic              step_done
);

    logic halt_req;

    stepclk_halt_detect #(
        .NUM_PE (NUM_PE)
    ) i_halt (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .halt_n   (halt_n),
        .halt_en  (halt_en),
        .halt_req (halt_req)
    );

    stepclk_seq #(
        .CNT_W (CNT_W)
    ) i_seq (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_arg   (cmd_arg),
        .fifo_wr   (fifo_wr),
        .halt_req  (halt_req),
        .clk_en    (clk_en),
        .busy      (busy),
        .step_done (step_done)
    );

    AST_DONE_STOPPED: assert property (@(posedge clk_ref) disable iff (!rst_n)
        step_done |-> !busy); // R5
    AST_RESET_QUIET: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(rst_n) |-> !clk_en); // R1

endmodule

// File: tb/test_stepclk_ctrl.sv
`timescale 1ns/1ps
module test_stepclk_ctrl;

    localparam int unsigned NUM_PE = 3;
    localparam int unsigned CNT_W  = 16;

    logic              clk_ref = 1'b0;
    logic              rst_n   = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op  = 2'd0;
    logic [CNT_W-1:0]  cmd_arg = '0;
    logic              fifo_wr = 1'b0;
    logic [NUM_PE-1:0] halt_n  = '1;
    logic [NUM_PE-1:0] halt_en = '0;
    logic              clk_en;
    logic              busy;
    logic              step_done;

    int checks   = 0;
    int errors   = 0;
    bit finished = 1'b0;

    always #2.5 clk_ref = ~clk_ref;

    stepclk_ctrl #(.NUM_PE(NUM_PE), .CNT_W(CNT_W)) i_stepclk_ctrl (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_arg   (cmd_arg),
        .fifo_wr   (fifo_wr),
        .halt_n    (halt_n),
        .halt_en   (halt_en),
        .clk_en    (clk_en),
        .busy      (busy),
        .step_done (step_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the command.
    task automatic do_cmd(input logic [1:0] op, input int arg);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_arg   = CNT_W'(arg);
        @(negedge clk_ref);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_wr();
        fifo_wr = 1'b1;
        @(negedge clk_ref);
        fifo_wr = 1'b0;
    endtask

    // Counts consecutive enabled samples from the current negedge.
    task automatic run_len(input bit exp_busy, output int n, output int bad);
        n = 0;
        bad = 0;
        while (clk_en === 1'b1 && n < 2000) begin
            if (busy !== exp_busy || step_done !== 1'b0) bad++;
            n++;
            @(negedge clk_ref);
        end
    endtask

    task automatic idle_for(input int cycles, output int high);
        high = 0;
        for (int i = 0; i < cycles; i++) begin
            if (clk_en === 1'b1 || step_done === 1'b1) high++;
            @(negedge clk_ref);
        end
    endtask

    task automatic t_reset();
        check("R1 clk_en after reset", int'(clk_en), 0);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 step_done after reset", int'(step_done), 0);
    endtask

    task automatic t_free_run();
        int lows = 0;
        do_cmd(2'd1, 0);
        for (int i = 0; i < 20; i++) begin
            if (clk_en !== 1'b1 || busy !== 1'b0) lows++;
            @(negedge clk_ref);
        end
        check("R2 free-run every cycle", lows, 0);
        check("R11 busy low in free-run", int'(busy), 0);
        do_cmd(2'd0, 0);
        check("R2 stop drops clk_en", int'(clk_en), 0);
        check("R5 no done on stop", int'(step_done), 0);
    endtask

    task automatic t_step(input int n_req);
        int n, bad;
        do_cmd(2'd2, n_req);
        run_len(1'b1, n, bad);
        check($sformatf("R3 step %0d edge count", n_req), n, n_req);
        check("R11 busy during countdown", bad, 0);
        check("R5 done after countdown", int'(step_done), 1);
        check("R11 busy low after countdown", int'(busy), 0);
        @(negedge clk_ref);
        check("R5 done one cycle", int'(step_done), 0);
    endtask

    task automatic t_step_zero();
        int high;
        do_cmd(2'd2, 0);
        idle_for(6, high);
        check("R4 step zero ignored", high, 0);
    endtask

    task automatic t_fifo();
        int n, bad, high;
        do_cmd(2'd3, 5);
        idle_for(4, high);
        check("R6 armed keeps clock stopped", high, 0);
        for (int k = 0; k < 2; k++) begin
            pulse_wr();
            run_len(1'b1, n, bad);
            check("R6 burst length", n, 5);
            check("R11 busy during burst", bad, 0);
            check("R5 done after burst", int'(step_done), 1);
            @(negedge clk_ref);
        end
    endtask

    task automatic t_fifo_add();
        int n, bad;
        do_cmd(2'd3, 4);
        pulse_wr();
        // first enabled sample here; second write overlaps the burst
        @(negedge clk_ref);
        pulse_wr();
        run_len(1'b1, n, bad);
        check("R7 overlapping bursts add", n + 2, 8);
        check("R5 done after merged burst", int'(step_done), 1);
        @(negedge clk_ref);
    endtask

    task automatic t_fifo_ignored();
        int high;
        do_cmd(2'd3, 0);
        pulse_wr();
        idle_for(8, high);
        check("R8 write ignored when disarmed", high, 0);
        do_cmd(2'd2, 3);
        while (clk_en === 1'b1) @(negedge clk_ref);
        @(negedge clk_ref);
        pulse_wr();
        idle_for(8, high);
        check("R8 write ignored after step", high, 0);
    endtask

    task automatic t_halt_free();
        int n, bad, high;
        halt_en = 3'b010;
        do_cmd(2'd1, 0);
        repeat (5) @(negedge clk_ref);
        halt_n[1] = 1'b0;
        @(negedge clk_ref);
        run_len(1'b0, n, bad);
        check("R9 halt from free-run latency", n, 5);
        idle_for(6, high);
        check("R5 no done after halt", high, 0);
        halt_n[1] = 1'b1;
        repeat (4) @(negedge clk_ref);
    endtask

    task automatic t_halt_count();
        int n, bad, high;
        halt_en = 3'b001;
        do_cmd(2'd2, 60);
        repeat (9) @(negedge clk_ref);
        halt_n[0] = 1'b0;
        @(negedge clk_ref);
        n = 0;
        while (clk_en === 1'b1 && n < 100) begin n++; @(negedge clk_ref); end
        check("R9 halt cuts countdown", n, 5);
        check("R11 busy low after halt", int'(busy), 0);
        idle_for(6, high);
        check("R5 no done on halted countdown", high, 0);
    endtask

    task automatic t_halt_ignored();
        int lows = 0;
        int high;
        // halt_n[0] is low, enable 0 only; line 2 disabled
        halt_en = 3'b001;
        do_cmd(2'd1, 0);
        halt_n[2] = 1'b0;
        halt_n[0] = 1'b1;
        for (int i = 0; i < 12; i++) begin
            if (clk_en !== 1'b1) lows++;
            @(negedge clk_ref);
        end
        check("R10 disabled fall and rising edge ignored", lows, 0);
        do_cmd(2'd0, 0);
        halt_n[0] = 1'b0;
        idle_for(6, high);
        check("R10 clock stays stopped", high, 0);
        do_cmd(2'd1, 0);
        lows = 0;
        for (int i = 0; i < 12; i++) begin
            if (clk_en !== 1'b1) lows++;
            @(negedge clk_ref);
        end
        check("R10 fall while stopped has no effect", lows, 0);
        do_cmd(2'd0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk_ref);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk_ref);
        @(negedge clk_ref);
        t_reset();
        t_free_run();
        t_step(1);
        t_step(7);
        t_step(40);
        t_step_zero();
        t_fifo();
        t_fifo_add();
        t_fifo_ignored();
        t_halt_free();
        t_halt_count();
        t_halt_ignored();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk_ref);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule